// File: doc/BRIEF.md
# Page Invalidate Walker

This block clears one 4-Kbyte page out of a pair of sectored caches (data cache and instruction cache). Software writes a page number, with a flush option, through a small register port. The engine then walks all line addresses of that page in the data tag array first, then in the instruction tag array. Each array sector holds two 32-byte lines: the lower one has address bit 5 clear and the upper one has it set.

For each line, the engine reads the tag entry and compares its tag with the page. A matching valid line has its valid and modified bits cleared. When the flush option is set, a matching modified line is first handed to a writeback port, and the engine waits for the acknowledge. Lines that belong to another page, and lines that are not valid, are never written.

While the walk runs, the engine reports busy and ignores further register writes. A one-cycle done pulse marks the end of the walk.

Top module: `pfi_engine`

## Requirements
- R1: After reset, busy, done, tag_req, tag_we and wb_req are all 0.
- R2: A cfg_we pulse while idle latches cfg_page and cfg_flush, and busy is 1 from the next clock edge.
- R3: A cfg_we while busy is ignored. The page being walked does not change, and no second walk follows the first.
- R4: The walk reads tag indices 0 to 127 in ascending order with tag_arr=0 (data array), then again with tag_arr=1 (instruction array). Each line costs 2 cycles (read, compare), plus 1 for an invalidate, plus the writeback wait.
- R5: Every valid entry whose tag equals the page is invalidated (valid and modified cleared) in both arrays, for the lower (bit 5 = 0) and the upper (bit 5 = 1) line of every sector.
- R6: Entries whose tag differs from the page are left unchanged.
- R7: tag_we is issued only for entries that were read as valid with a matching tag.
- R8: With flush set, a matching modified entry raises wb_req with wb_addr = {page, index, 5'b0}. wb_req and wb_addr hold until wb_ack, and the invalidate of the same index follows in the next cycle.
- R9: With flush clear, wb_req never rises, and modified matching entries are still invalidated.
- R10: done is high for exactly one cycle after the last line of the instruction array, and busy is 0 in that cycle.
- R11: At most one of tag_req, tag_we and wb_req is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_page | input | ADDR_W-12 | Page number (address bits above 11) |
| cfg_flush | input | 1 | Write back modified lines before invalidating |
| tag_req | output | 1 | Tag read; entry returned on tag_rvalid/tag_rmod/tag_rtag next cycle |
| tag_we | output | 1 | Clear valid and modified of entry tag_arr/tag_idx |
| tag_arr | output | 1 | Array select: 0 data, 1 instruction |
| tag_idx | output | SET_BITS | Set index (address bits 5 upward) |
| tag_rvalid | input | 1 | Valid bit of the read entry |
| tag_rmod | input | 1 | Modified bit of the read entry |
| tag_rtag | input | ADDR_W-5-SET_BITS | Tag of the read entry |
| wb_req | output | 1 | Writeback request, held until acknowledged |
| wb_addr | output | ADDR_W | Line address to write back |
| wb_ack | input | 1 | Writeback acknowledge |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
busy is due one edge after the accepted write. Tag entries arrive one edge after tag_req. tag_we follows the compare cycle directly, or follows the edge that sees wb_req and wb_ack together. done rises on the edge that retires line 127 of the instruction array.

The bench drives inputs and samples outputs on falling edges, so each result is read half a cycle after the edge that produced it. It then compares the count of busy cycles against a per-line sum (2, plus 1 per hit, plus the acknowledge delay plus 2 per writeback), so a single missing or extra cycle anywhere in the walk is caught.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  localparam int LINE_OFF = 5;   // 32-byte lines
  localparam int PAGE_OFF = 12;  // 4-Kbyte pages

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CMP,
    ST_WBACK,
    ST_CLEAR
  } pfi_state_e;
endpackage

// File: rtl/pfi_walker.sv
module pfi_walker #(
  parameter int LINE_W   = 7,
  parameter int N_ARRAYS = 2,
  parameter int ARR_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [LINE_W-1:0] line,
  output logic [ARR_W-1:0]  arr,
  output logic              last
);
  localparam logic [ARR_W-1:0] ARR_LAST = ARR_W'(N_ARRAYS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      line <= '0;
      arr  <= '0;
    end else if (step) begin
      line <= line + 1'b1;
      if (&line) arr <= arr + 1'b1;
    end
  end

  assign last = (&line) && (arr == ARR_LAST);
endmodule

// File: rtl/pfi_match.sv
module pfi_match #(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 7,
  parameter int LINE_W   = 7,
  parameter int PAGE_W   = 20,
  parameter int TAG_W    = 20
) (
  input  logic [PAGE_W-1:0]   page,
  input  logic [LINE_W-1:0]   line,
  input  logic                rd_valid,
  input  logic [TAG_W-1:0]    rd_tag,
  output logic [ADDR_W-1:0]   line_addr,
  output logic [SET_BITS-1:0] idx,
  output logic                hit
);
  import pfi_pkg::*;

  function automatic logic [ADDR_W-1:0] f_line_addr(input logic [PAGE_W-1:0] pg,
                                                    input logic [LINE_W-1:0] ln);
    return {pg, ln, {LINE_OFF{1'b0}}};
  endfunction

  function automatic logic [SET_BITS-1:0] f_index(input logic [ADDR_W-1:0] a);
    return a[LINE_OFF +: SET_BITS];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  assign line_addr = f_line_addr(page, line);
  assign idx       = f_index(line_addr);
  assign hit       = rd_valid && (rd_tag == f_tag(line_addr));
endmodule

// File: rtl/pfi_ctrl.sv
module pfi_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hit,
  input  logic rd_mod,
  input  logic flush,
  input  logic wb_ack,
  input  logic last,
  output logic tag_req,
  output logic tag_we,
  output logic wb_req,
  output logic step,
  output logic busy,
  output logic done,
  output logic chk_hit
);
  import pfi_pkg::*;

  pfi_state_e state, nxt;
  logic       finish;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= finish;
    end
  end

  always_comb begin
    nxt    = state;
    step   = 1'b0;
    finish = 1'b0;
    unique case (state)
      ST_IDLE:  if (start) nxt = ST_READ;
      ST_READ:  nxt = ST_CMP;
      ST_CMP: begin
        if (hit) begin
          nxt = (flush && rd_mod) ? ST_WBACK : ST_CLEAR;
        end else begin
          step   = 1'b1;
          finish = last;
          nxt    = last ? ST_IDLE : ST_READ;
        end
      end
      ST_WBACK: if (wb_ack) nxt = ST_CLEAR;
      ST_CLEAR: begin
        step   = 1'b1;
        finish = last;
        nxt    = last ? ST_IDLE : ST_READ;
      end
      default:  nxt = ST_IDLE;
    endcase
  end

  assign tag_req = (state == ST_READ);
  assign tag_we  = (state == ST_CLEAR);
  assign wb_req  = (state == ST_WBACK);
  assign busy    = (state != ST_IDLE);
  assign chk_hit = (state == ST_CMP) && hit;
endmodule

// File: rtl/pfi_engine.sv
module pfi_engine #(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 7,
  parameter int N_ARRAYS = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic [ADDR_W-pfi_pkg::PAGE_OFF-1:0]    cfg_page,
  input  logic                                   cfg_flush,
  output logic                                   tag_req,
  output logic                                   tag_we,
  output logic [((N_ARRAYS > 1) ? $clog2(N_ARRAYS) : 1)-1:0] tag_arr,
  output logic [SET_BITS-1:0]                    tag_idx,
  input  logic                                   tag_rvalid,
  input  logic                                   tag_rmod,
  input  logic [ADDR_W-pfi_pkg::LINE_OFF-SET_BITS-1:0] tag_rtag,
  output logic                                   wb_req,
  output logic [ADDR_W-1:0]                      wb_addr,
  input  logic                                   wb_ack,
  output logic                                   busy,
  output logic                                   done
);
  import pfi_pkg::*;

  localparam int PAGE_W = ADDR_W - PAGE_OFF;
  localparam int LINE_W = PAGE_OFF - LINE_OFF;
  localparam int TAG_W  = ADDR_W - LINE_OFF - SET_BITS;
  localparam int ARR_W  = (N_ARRAYS > 1) ? $clog2(N_ARRAYS) : 1;

  logic [PAGE_W-1:0] page_q;
  logic              flush_q;
  logic              start, walk_step, walk_last, hit_w, chk_hit;
  logic [LINE_W-1:0] line_w;
  logic [ARR_W-1:0]  arr_w;
  logic [ADDR_W-1:0] line_addr_w;

  assign start = cfg_we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      flush_q <= 1'b0;
    end else if (start) begin
      page_q  <= cfg_page;
      flush_q <= cfg_flush;
    end
  end

  pfi_walker #(.LINE_W(LINE_W), .N_ARRAYS(N_ARRAYS), .ARR_W(ARR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(walk_step),
    .line(line_w), .arr(arr_w), .last(walk_last)
  );

  pfi_match #(.ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .LINE_W(LINE_W),
              .PAGE_W(PAGE_W), .TAG_W(TAG_W)) u_match (
    .page(page_q), .line(line_w), .rd_valid(tag_rvalid), .rd_tag(tag_rtag),
    .line_addr(line_addr_w), .idx(tag_idx), .hit(hit_w)
  );

  pfi_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .hit(hit_w), .rd_mod(tag_rmod),
    .flush(flush_q), .wb_ack(wb_ack), .last(walk_last),
    .tag_req(tag_req), .tag_we(tag_we), .wb_req(wb_req), .step(walk_step),
    .busy(busy), .done(done), .chk_hit(chk_hit)
  );

  assign tag_arr = arr_w;
  assign wb_addr = line_addr_w;
endmodule

// File: rtl/pfi_engine_chk.sv
module pfi_engine_chk #(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 7,
  parameter int PAGE_W   = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic                tag_req,
  input logic                tag_we,
  input logic [SET_BITS-1:0] tag_idx,
  input logic                wb_req,
  input logic                wb_ack,
  input logic [ADDR_W-1:0]   wb_addr,
  input logic                flush_q,
  input logic [PAGE_W-1:0]   page_q,
  input logic                chk_hit
);
  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_addr));

  // R8
  wb_then_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_ack |=> tag_we && $stable(tag_idx));

  // R9
  no_flush_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_q |-> !wb_req);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(page_q));

  // R7
  clear_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we && !$past(wb_req) |-> $past(chk_hit));

  // R11
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tag_req, tag_we, wb_req}));
endmodule

bind pfi_engine pfi_engine_chk #(
  .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .PAGE_W(PAGE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .tag_req(tag_req),
  .tag_we(tag_we), .tag_idx(tag_idx), .wb_req(wb_req), .wb_ack(wb_ack),
  .wb_addr(wb_addr), .flush_q(flush_q), .page_q(page_q), .chk_hit(chk_hit)
);

// File: tb/sim_pfi_engine.sv
`timescale 1ns/1ps
module sim_pfi_engine;
  localparam int NL = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_flush = 1'b0;
  logic [19:0] cfg_page = '0;
  logic        tag_req, tag_we, wb_req, busy, done;
  logic [0:0]  tag_arr;
  logic [6:0]  tag_idx;
  logic        tag_rvalid = 1'b0, tag_rmod = 1'b0;
  logic [19:0] tag_rtag = '0;
  logic [31:0] wb_addr;
  logic        wb_ack = 1'b0;

  always #2 clk = ~clk;

  pfi_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_flush(cfg_flush),
    .tag_req(tag_req), .tag_we(tag_we), .tag_arr(tag_arr), .tag_idx(tag_idx),
    .tag_rvalid(tag_rvalid), .tag_rmod(tag_rmod), .tag_rtag(tag_rtag),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0;
  logic        v_mem [0:1][0:NL-1];
  logic        m_mem [0:1][0:NL-1];
  logic [19:0] t_mem [0:1][0:NL-1];
  logic        e_v   [0:1][0:NL-1];
  logic        e_m   [0:1][0:NL-1];
  logic [19:0] e_t   [0:1][0:NL-1];

  logic [19:0] cur_page = '0;
  logic        run_flush = 1'b0;
  int ack_lat = 0, wcnt = 0;
  int reads = 0, seq_err = 0, wbs = 0, wb_err = 0, clears = 0, we_err = 0;
  int exp_line = 0, exp_arr = 0;
  logic wb_seen = 1'b0;
  int   wb_seen_idx = 0, wb_seen_arr = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // tag array and writeback responder
  always @(posedge clk) begin
    if (rst_n) begin
      if (tag_req) begin
        tag_rvalid <= v_mem[tag_arr][tag_idx];
        tag_rmod   <= m_mem[tag_arr][tag_idx];
        tag_rtag   <= t_mem[tag_arr][tag_idx];
        if (int'(tag_idx) != exp_line || int'(tag_arr) != exp_arr) seq_err++;
        reads++;
        if (exp_line == NL - 1) begin exp_line = 0; exp_arr++; end
        else exp_line++;
      end
      if (wb_req && wb_ack) begin
        wbs++;
        if (wb_addr != {cur_page, tag_idx, 5'b0} || !run_flush || !m_mem[tag_arr][tag_idx])
          wb_err++;
        wb_seen = 1'b1; wb_seen_idx = int'(tag_idx); wb_seen_arr = int'(tag_arr);
      end
      if (tag_we) begin
        clears++;
        if (!v_mem[tag_arr][tag_idx] || t_mem[tag_arr][tag_idx] != cur_page ||
            (run_flush && m_mem[tag_arr][tag_idx] &&
             !(wb_seen && wb_seen_idx == int'(tag_idx) && wb_seen_arr == int'(tag_arr))))
          we_err++;
        v_mem[tag_arr][tag_idx] <= 1'b0;
        m_mem[tag_arr][tag_idx] <= 1'b0;
        wb_seen = 1'b0;
      end
      if (wb_req && !wb_ack) begin
        if (wcnt == ack_lat) begin wb_ack <= 1'b1; wcnt = 0; end
        else wcnt++;
      end else wb_ack <= 1'b0;
    end
  end

  task automatic run_walk(input int variant, input logic [19:0] pg, input logic [19:0] oth,
                          input bit fl, input int lat);
    int exp_cyc = 0, exp_wb = 0, exp_clr = 0, bcnt = 0, bad5 = 0, bad6 = 0;
    for (int a = 0; a < 2; a++)
      for (int i = 0; i < NL; i++) begin
        bit v, mt, md;
        v  = (variant == 0) ? 1'b0 : (variant == 3) ? 1'b1 : (((i * 5 + a * 3 + variant) % 4) != 0);
        mt = (variant == 3) ? 1'b1 : (((i + a + variant) % 3) != 0);
        md = (variant == 3) ? 1'b1 : (((i ^ variant) & 1) != 0);
        v_mem[a][i] = v; m_mem[a][i] = md; t_mem[a][i] = mt ? pg : oth;
        e_v[a][i] = v && !mt; e_m[a][i] = (v && mt) ? 1'b0 : md; e_t[a][i] = t_mem[a][i];
        exp_cyc += 2;
        if (v && mt) begin
          exp_cyc += 1; exp_clr++;
          if (fl && md) begin exp_cyc += lat + 2; exp_wb++; end
        end
      end
    cur_page = pg; run_flush = fl; ack_lat = lat; wcnt = 0;
    reads = 0; seq_err = 0; wbs = 0; wb_err = 0; clears = 0; we_err = 0;
    exp_line = 0; exp_arr = 0; wb_seen = 1'b0;
    cfg_page = pg; cfg_flush = fl; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check(busy === 1'b1, "R2 busy after write", int'(busy), 1);
    // R3: write of another page while busy
    cfg_page = oth; cfg_flush = ~fl; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    bcnt = 2;
    while (!done && bcnt < 20000) begin
      @(negedge clk);
      if (busy) bcnt++;
    end
    check(busy === 1'b0, "R10 busy low with done", int'(busy), 0);
    check(bcnt == exp_cyc, "R4 walk cycle count", bcnt, exp_cyc);
    check(reads == 2 * NL && seq_err == 0, "R4 read order", reads - seq_err, 2 * NL);
    @(negedge clk);
    check(done === 1'b0, "R10 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R3 no second walk", int'(busy), 0);
    for (int a = 0; a < 2; a++)
      for (int i = 0; i < NL; i++) begin
        if (t_mem[a][i] == pg && v_mem[a][i]) bad5++;
        if (v_mem[a][i] != e_v[a][i] || m_mem[a][i] != e_m[a][i] || t_mem[a][i] != e_t[a][i]) bad6++;
      end
    check(bad5 == 0, "R5 page lines invalid in both halves", bad5, 0);
    check(bad6 == 0, "R6 other lines unchanged", bad6, 0);
    check(clears == exp_clr && we_err == 0, "R7 invalidate writes", clears, exp_clr);
    if (fl) check(wbs == exp_wb && wb_err == 0, "R8 writebacks", wbs, exp_wb);
    else    check(wbs == 0, "R9 no writeback without flush", wbs, 0);
    check(tag_req === 1'b0 && tag_we === 1'b0 && wb_req === 1'b0, "R11 ports idle", 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && tag_req === 1'b0 && tag_we === 1'b0 && wb_req === 1'b0,
          "R1 reset outputs", int'({busy, done, tag_req, tag_we, wb_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_walk(0, 20'h00012, 20'h00013, 1'b0, 0);
    run_walk(1, 20'h0ABCD, 20'h0ABCE, 1'b0, 0);
    run_walk(1, 20'h0ABCD, 20'h12345, 1'b1, 0);
    run_walk(2, 20'hFFFFF, 20'h00000, 1'b1, 3);
    run_walk(3, 20'h55555, 20'hAAAAA, 1'b1, 1);
    run_walk(3, 20'h00001, 20'h00002, 1'b0, 0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end
endmodule